// File: doc/BRIEF.md
# Hebbian Ternary Weight Synapse

This block is a digital model of one learning synapse. It keeps a bounded, resistance-like state as an unsigned fraction of full scale. On each clock edge where the update strobe is high, the pre-synaptic and post-synaptic activity inputs decide how that state moves:

- Both inputs active: the state drops by a fixed step. A lower value is a stronger connection.
- Pre-synaptic active and post-synaptic quiet: the state rises by the same step.
- Pre-synaptic quiet: the state holds.

The state saturates at both ends of its range. It is also read out continuously as a balanced-ternary weight through three zones:

- Low state reads as excitatory (+1).
- Middle state reads as neutral (0).
- High state reads as inhibitory (-1).

The design is built around two enumerations. The action decoder picks one of three actions each cycle:

- `ACT_HOLD`: the state register keeps its value.
- `ACT_STRENGTHEN`: the state register takes a downward step, saturating at zero.
- `ACT_WEAKEN`: the state register takes an upward step, saturating at full scale.

Transitions happen only on a clock edge. Reset forces the state to mid-scale. The zone classifier maps the current state to one of three zones, each of which drives a fixed two-bit code:

- `ZN_EXCITE` drives code 01.
- `ZN_NEUTRAL` drives code 00.
- `ZN_INHIBIT` drives code 11.

Top module: `hebb_synapse`

## Requirements
- R1: While reset is asserted (`rst_n` low), the state takes the mid-scale value 32768 (2^(W-1)), which reads as weight code 00 (neutral).
- R2: On a clock edge with `upd_i`, `pre_i` and `post_i` all high, the state decreases by STEP (default 66) when it is at least STEP.
- R3: On a clock edge with `upd_i` and `pre_i` high and `post_i` low, the state increases by STEP when the result does not exceed 65535.
- R4: On a clock edge with `pre_i` low, the state does not change, whatever `post_i` is.
- R5: On a clock edge with `upd_i` low, the state does not change, whatever `pre_i` and `post_i` are.
- R6: A strengthening update with the state below STEP leaves the state at 0.
- R7: A weakening update with the state above 65535-STEP leaves the state at 65535.
- R8: `wt_o` follows `state_o` combinationally. A state below 21627 reads 01 (+1), a state above 43253 reads 11 (-1), and any state from 21627 to 43253 inclusive reads 00 (0).
- R9: `wt_o` never carries the unused code 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to mid-scale |
| upd_i | input | 1 | Update strobe; the state may change only while high |
| pre_i | input | 1 | Pre-synaptic activity |
| post_i | input | 1 | Post-synaptic activity |
| wt_o | output | 2 | Ternary weight: 00 = 0, 01 = +1, 11 = -1 |
| state_o | output | W (16) | Raw state as an unsigned fraction of full scale |

## Verification
On every cycle, the bound checker confirms the following:
- Each action moves the state by exactly one step, or saturates it at the correct rail.
- The hold conditions keep the state stable.
- The ternary code matches the zone of the current state.
- The illegal code never appears.

Only the bench's scenarios show that long runs of updates actually reach both rails from mid-scale and that the reset value is the neutral mid-point. A fine-step instance lets the bench walk the state one count at a time across both zone thresholds. This exercises the exact boundary values, which the default step cannot land on.

// File: rtl/hebb_pkg.sv
package hebb_pkg;

    // Update action selected for the current cycle
    typedef enum logic [1:0] {
        ACT_HOLD       = 2'd0,
        ACT_STRENGTHEN = 2'd1,
        ACT_WEAKEN     = 2'd2
    } hebb_act_e;

    // Readout zone of the stored state
    typedef enum logic [1:0] {
        ZN_NEUTRAL = 2'd0,
        ZN_EXCITE  = 2'd1,
        ZN_INHIBIT = 2'd2
    } hebb_zone_e;

    // Balanced-ternary output codes
    localparam logic [1:0] TRIT_ZERO = 2'b00;
    localparam logic [1:0] TRIT_POS  = 2'b01;
    localparam logic [1:0] TRIT_NEG  = 2'b11;

endpackage

// File: rtl/hebb_rule.sv
module hebb_rule
    import hebb_pkg::*;
(
    input  logic      upd_i,
    input  logic      pre_i,
    input  logic      post_i,
    output hebb_act_e act_o
);

    // Correlated firing strengthens, uncorrelated firing weakens,
    // a silent pre-synaptic side leaves the synapse alone.
    always_comb begin
        unique case ({upd_i, pre_i, post_i})
            3'b111:  act_o = ACT_STRENGTHEN;
            3'b110:  act_o = ACT_WEAKEN;
            default: act_o = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/hebb_accum.sv
module hebb_accum
    import hebb_pkg::*;
#(
    parameter int W    = 16,
    parameter int STEP = 66
) (
    input  logic         clk,
    input  logic         rst_n,
    input  hebb_act_e    act_i,
    output logic [W-1:0] state_o
);

    localparam logic [W-1:0] INIT_V = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_V  = '1;
    localparam logic [W-1:0] STEP_V = W'(STEP);
    localparam logic [W-1:0] TOP_V  = MAX_V - STEP_V;

    logic [W-1:0] st_q;
    logic [W-1:0] st_d;

    // Next-state selection with saturation at both rails
    always_comb begin
        st_d = st_q;
        unique case (act_i)
            ACT_HOLD:       st_d = st_q;
            ACT_STRENGTHEN: st_d = (st_q < STEP_V) ? '0 : (st_q - STEP_V);
            ACT_WEAKEN:     st_d = (st_q > TOP_V) ? MAX_V : (st_q + STEP_V);
            default:        st_d = st_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= INIT_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/hebb_zone.sv
module hebb_zone
    import hebb_pkg::*;
#(
    parameter int W     = 16,
    parameter int LO_TH = 21627,
    parameter int HI_TH = 43253
) (
    input  logic [W-1:0] state_i,
    output logic [1:0]   wt_o
);

    localparam logic [W-1:0] LO_V = W'(LO_TH);
    localparam logic [W-1:0] HI_V = W'(HI_TH);

    hebb_zone_e zone;

    // Classify the state; low resistance means excitatory
    always_comb begin
        if (state_i < LO_V) begin
            zone = ZN_EXCITE;
        end else if (state_i > HI_V) begin
            zone = ZN_INHIBIT;
        end else begin
            zone = ZN_NEUTRAL;
        end
    end

    // Zone to ternary code
    always_comb begin
        unique case (zone)
            ZN_EXCITE:  wt_o = TRIT_POS;
            ZN_INHIBIT: wt_o = TRIT_NEG;
            ZN_NEUTRAL: wt_o = TRIT_ZERO;
            default:    wt_o = TRIT_ZERO;
        endcase
    end

endmodule

// File: rtl/hebb_synapse.sv
module hebb_synapse
    import hebb_pkg::*;
#(
    parameter int W     = 16,
    parameter int STEP  = 66,
    parameter int LO_TH = 21627,
    parameter int HI_TH = 43253
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_i,
    input  logic         pre_i,
    input  logic         post_i,
    output logic [1:0]   wt_o,
    output logic [W-1:0] state_o
);

    hebb_act_e    act;
    logic [W-1:0] state;

    hebb_rule u_rule (
        .upd_i  (upd_i),
        .pre_i  (pre_i),
        .post_i (post_i),
        .act_o  (act)
    );

    hebb_accum #(
        .W    (W),
        .STEP (STEP)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act),
        .state_o (state)
    );

    hebb_zone #(
        .W     (W),
        .LO_TH (LO_TH),
        .HI_TH (HI_TH)
    ) u_zone (
        .state_i (state),
        .wt_o    (wt_o)
    );

    assign state_o = state;

endmodule

// File: rtl/hebb_synapse_chk.sv
module hebb_synapse_chk #(
    parameter int W     = 16,
    parameter int STEP  = 66,
    parameter int LO_TH = 21627,
    parameter int HI_TH = 43253
) (
    input logic         clk,
    input logic         rst_n,
    input logic         upd_i,
    input logic         pre_i,
    input logic         post_i,
    input logic [1:0]   wt_o,
    input logic [W-1:0] state_o
);

    localparam logic [W-1:0] INIT_V = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_V  = '1;
    localparam logic [W-1:0] STEP_V = W'(STEP);
    localparam logic [W-1:0] TOP_V  = MAX_V - STEP_V;
    localparam logic [W-1:0] LO_V   = W'(LO_TH);
    localparam logic [W-1:0] HI_V   = W'(HI_TH);

    logic rst_seen = 1'b0;
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    a_r1_mid_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> (state_o == INIT_V));

    a_r2_strengthen_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && pre_i && post_i && state_o >= STEP_V)
        |=> (state_o == $past(state_o) - STEP_V));

    a_r3_weaken_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && pre_i && !post_i && state_o <= TOP_V)
        |=> (state_o == $past(state_o) + STEP_V));

    a_r4_pre_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_i |=> $stable(state_o));

    a_r5_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(state_o));

    a_r6_floor_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && pre_i && post_i && state_o < STEP_V) |=> (state_o == '0));

    a_r7_ceiling_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && pre_i && !post_i && state_o > TOP_V) |=> (state_o == MAX_V));

    a_r8_zone_code: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o < LO_V) ? (wt_o == 2'b01) :
         (state_o > HI_V) ? (wt_o == 2'b11) : (wt_o == 2'b00)));

    a_r9_no_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        wt_o != 2'b10);

endmodule

bind hebb_synapse hebb_synapse_chk #(
    .W     (W),
    .STEP  (STEP),
    .LO_TH (LO_TH),
    .HI_TH (HI_TH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (upd_i),
    .pre_i   (pre_i),
    .post_i  (post_i),
    .wt_o    (wt_o),
    .state_o (state_o)
);

// File: tb/hebb_synapse_test.sv
`timescale 1ns/1ps
module hebb_synapse_test;

    localparam int STEP = 66;
    localparam int MAXV = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0, pre = 1'b0, post = 1'b0;
    logic f_upd = 1'b0, f_pre = 1'b0, f_post = 1'b0;
    logic [1:0]  wt, f_wt;
    logic [15:0] st, f_st;

    int n_checks = 0;
    int n_fail = 0;
    int m = 32768;
    int fm = 32768;
    bit done = 0;

    always #4 clk = ~clk;

    hebb_synapse uut (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .pre_i(pre), .post_i(post),
        .wt_o(wt), .state_o(st)
    );

    hebb_synapse #(.STEP(1)) uut_fine (
        .clk(clk), .rst_n(rst_n), .upd_i(f_upd), .pre_i(f_pre), .post_i(f_post),
        .wt_o(f_wt), .state_o(f_st)
    );

    function automatic logic [1:0] exp_code(int s);
        if (s < 21627) return 2'b01;
        else if (s > 43253) return 2'b11;
        else return 2'b00;
    endfunction

    function automatic int next_state(int s, logic u, logic p, logic q, int step);
        if (!u || !p) return s;
        if (q) return (s < step) ? 0 : s - step;
        return (s > MAXV - step) ? MAXV : s + step;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd = 0; pre = 0; post = 0;
        f_upd = 0; f_pre = 0; f_post = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m = 32768;
        fm = 32768;
    endtask

    // One update on the default instance; results checked after the edge
    task automatic apply(string tag, logic u, logic p, logic q, bit chk_zone);
        @(negedge clk);
        upd = u; pre = p; post = q;
        @(negedge clk);
        upd = 0; pre = 0; post = 0;
        m = next_state(m, u, p, q, STEP);
        check(tag, int'(st), m);
        if (chk_zone) begin
            check("R8 zone", int'(wt), int'(exp_code(m)));
            check("R9 code legal", int'(wt == 2'b10), 0);
        end
    endtask

    task automatic fine_step(logic q);
        @(negedge clk);
        f_upd = 1; f_pre = 1; f_post = q;
        @(negedge clk);
        f_upd = 0; f_pre = 0; f_post = 0;
        fm = next_state(fm, 1'b1, 1'b1, q, 1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset state", int'(st), 32768);
        check("R1 reset weight", int'(wt), 0);
        @(negedge clk);
        check("R1 state held after release", int'(st), 32768);
    endtask

    task automatic t_strengthen();
        do_reset();
        for (int i = 0; i < 3; i++) apply("R2 strengthen", 1, 1, 1, 1);
        check("R2 net after three", int'(st), 32768 - 3 * STEP);
    endtask

    task automatic t_weaken();
        do_reset();
        for (int i = 0; i < 5; i++) apply("R3 weaken", 1, 1, 0, 1);
        check("R3 net after five", int'(st), 32768 + 5 * STEP);
    endtask

    task automatic t_pre_idle();
        do_reset();
        apply("R3 setup", 1, 1, 0, 0);
        apply("R4 pre idle post low", 1, 0, 0, 1);
        apply("R4 pre idle post high", 1, 0, 1, 1);
        check("R4 unchanged", int'(st), 32768 + STEP);
    endtask

    task automatic t_no_strobe();
        do_reset();
        apply("R5 no strobe correlated", 0, 1, 1, 1);
        apply("R5 no strobe uncorrelated", 0, 1, 0, 1);
        check("R5 unchanged", int'(st), 32768);
    endtask

    task automatic t_floor();
        do_reset();
        for (int i = 0; i < 505; i++) apply("R6 descend", 1, 1, 1, 1);
        check("R6 floor", int'(st), 0);
        check("R8 floor weight +1", int'(wt), 1);
        apply("R6 at floor", 1, 1, 1, 1);
        check("R6 stays zero", int'(st), 0);
    endtask

    task automatic t_ceiling();
        for (int i = 0; i < 1000; i++) apply("R7 ascend", 1, 1, 0, 1);
        check("R7 ceiling", int'(st), MAXV);
        check("R8 ceiling weight -1", int'(wt), 3);
        apply("R7 at ceiling", 1, 1, 0, 1);
        check("R7 stays max", int'(st), MAXV);
    endtask

    task automatic t_mixed();
        do_reset();
        for (int i = 0; i < 20; i++) begin
            apply("R2 R3 R4 mixed", 1, 1'(i % 3 != 0), 1'(i % 2 == 0), 1);
        end
    endtask

    // Unit-step instance walks across both thresholds exactly
    task automatic t_thresholds();
        do_reset();
        while (fm < 43255) begin
            fine_step(1'b0);
            if (fm >= 43252) begin
                check("R8 upper boundary state", int'(f_st), fm);
                check("R8 upper boundary weight", int'(f_wt), int'(exp_code(fm)));
            end
        end
        do_reset();
        while (fm > 21625) begin
            fine_step(1'b1);
            if (fm <= 21628) begin
                check("R8 lower boundary state", int'(f_st), fm);
                check("R8 lower boundary weight", int'(f_wt), int'(exp_code(fm)));
            end
        end
    endtask

    initial begin
        t_reset();
        t_strengthen();
        t_weaken();
        t_pre_idle();
        t_no_strobe();
        t_floor();
        t_ceiling();
        t_mixed();
        t_thresholds();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule